// File: doc/BRIEF.md
# Branch Trace Address Queue

This block keeps a short history of control-flow changes for a debugger. Each time the core takes a branch or enters an exception handler, it presents one event on the capture port. While tracing is enabled, the block turns that event into a source/destination address pair and pushes it onto a fixed-depth queue. The newest pair sits at the top. When the queue is full, the oldest pair falls off the bottom.

Software drains the history through three read addresses: a control word, a source-address register and a destination-address register. The source and destination registers always show the same pair, because they share one read position. Reading the source register has no side effect. Reading the destination register retires the top pair, and the next pair then appears in both registers. Turning tracing off and then on again discards the whole history.

Top module: `branch_trace_queue`

## Requirements
- R1: An event on `ev_valid` is captured only when the trace-enable bit (control bit 0) was already 1 before that clock edge. Events seen while tracing is off leave the queue unchanged.
- R2: For a branch event (`ev_is_exc` = 0), the captured source is `ev_br_addr` and the captured destination is `ev_br_target`.
- R3: For an exception event (`ev_is_exc` = 1), the captured source is `ev_exc_pc` and the captured destination is `ev_exc_handler`.
- R4: The queue holds DEPTH pairs (8 by default). The valid count saturates at DEPTH. A capture into a full queue keeps the newest DEPTH pairs and discards the oldest.
- R5: The newest pair is presented first. `reg_addr` 1 reads its source address and `reg_addr` 2 reads its destination address. `reg_addr` 3 reads zero.
- R6: A read of the source register (`reg_addr` 1) does not advance the queue. Repeated source reads return the same value, and the valid count does not change.
- R7: A destination read (`reg_addr` 2) while the count is nonzero removes the top pair. Both registers then present the next older pair, and the count drops by one.
- R8: When the queue is empty, source and destination reads return zero, and a destination read leaves the count at zero.
- R9: A control write that changes trace-enable from 0 to 1 invalidates every entry, so the count becomes 0. Clearing the enable bit alone keeps the entries readable.
- R10: If a capture and a destination read fall in the same cycle, the read takes the old top first and the new pair is then pushed. No other entry is lost, and the count is unchanged when it was nonzero.
- R11: A read of the control word (`reg_addr` 0) returns the enable in bit 0 and the valid count in bits 7:4, with all other bits zero. After reset, the enable and the count are both 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev_valid | input | 1 | A branch or exception event is presented this cycle |
| ev_is_exc | input | 1 | 1 = exception or interrupt, 0 = branch instruction |
| ev_br_addr | input | 32 | Address of the branch instruction |
| ev_br_target | input | 32 | Address of the branch target |
| ev_exc_pc | input | 32 | PC value saved on exception entry |
| ev_exc_handler | input | 32 | Entry address of the handler routine |
| ctrl_wr_en | input | 1 | Write strobe for the control word |
| ctrl_wr_trace_en | input | 1 | New value of the trace-enable bit |
| reg_rd_en | input | 1 | Read strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 source, 2 destination, 3 reserved |
| reg_rdata | output | 32 | Read data, valid in the same cycle as the strobe, zero when no read is made |

## Verification
The assertions watch the count on every cycle. They check that it stays within the depth, that it grows by one, saturates or holds as each push/pop combination requires, and that it drops to zero on re-enable. They also check that a capture lands at the top with the pair its event type selects, and that a source read never moves the queue. Only the bench scenarios can show that the whole order of a drained history is right: newest first, the oldest pair lost on overflow, and the older entries intact after a simultaneous capture and pop. These scenarios sweep the number of captures from zero to past the depth.

// File: rtl/btq_pkg.sv
package btq_pkg;
   typedef enum logic [1:0] {
      BTQ_REG_CTRL = 2'd0,
      BTQ_REG_SRC  = 2'd1,
      BTQ_REG_DST  = 2'd2,
      BTQ_REG_RSVD = 2'd3
   } btq_reg_e;

   localparam int unsigned BTQ_CTRL_EN_BIT  = 0;
   localparam int unsigned BTQ_CTRL_CNT_LSB = 4;
endpackage

// File: rtl/btq_pair_select.sv
module btq_pair_select #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              is_exc,
   input  logic [ADDR_W-1:0] br_addr,
   input  logic [ADDR_W-1:0] br_target,
   input  logic [ADDR_W-1:0] exc_pc,
   input  logic [ADDR_W-1:0] exc_handler,
   output logic [ADDR_W-1:0] pair_src,
   output logic [ADDR_W-1:0] pair_dst
);
   always_comb begin
      if (is_exc) begin
         pair_src = exc_pc;
         pair_dst = exc_handler;
      end else begin
         pair_src = br_addr;
         pair_dst = br_target;
      end
   end
endmodule

// File: rtl/btq_ctrl.sv
module btq_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic wr_en,
   input  logic wr_val,
   output logic trace_en,
   output logic invalidate
);
   logic en_q;

   always_ff @(posedge clk) begin
      if (rst)        en_q <= 1'b0;
      else if (wr_en) en_q <= wr_val;
   end

   assign trace_en   = en_q;
   assign invalidate = wr_en && wr_val && !en_q;

   // R11
   reset_off_chk: assert property (@(posedge clk) rst |=> !trace_en);
endmodule

// File: rtl/btq_lifo.sv
module btq_lifo #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DEPTH      = 8,
   parameter bit          RESET_DATA = 1'b1,
   localparam int unsigned CNT_W     = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear,
   input  logic              push,
   input  logic              pop_req,
   input  logic [ADDR_W-1:0] push_src,
   input  logic [ADDR_W-1:0] push_dst,
   output logic [ADDR_W-1:0] top_src,
   output logic [ADDR_W-1:0] top_dst,
   output logic [CNT_W-1:0]  count
);
   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
   localparam logic [CNT_W-1:0] ONE_CNT  = CNT_W'(1);

   initial begin
      assert (DEPTH >= 2) else $fatal(1, "btq_lifo: DEPTH must be at least 2");
      assert (ADDR_W >= 8) else $fatal(1, "btq_lifo: ADDR_W too small");
   end

   logic [ADDR_W-1:0] src_q   [DEPTH];
   logic [ADDR_W-1:0] dst_q   [DEPTH];
   logic [ADDR_W-1:0] src_nxt [DEPTH];
   logic [ADDR_W-1:0] dst_nxt [DEPTH];
   logic [CNT_W-1:0]  cnt_q, cnt_nxt;
   logic pop_eff, shift_dn, shift_up;

   assign pop_eff  = pop_req && (cnt_q != '0);
   assign shift_dn = push && !pop_eff;
   assign shift_up = pop_eff && !push;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      if (i == 0) begin : g_top
         assign src_nxt[i] = push ? push_src : (shift_up ? src_q[i+1] : src_q[i]);
         assign dst_nxt[i] = push ? push_dst : (shift_up ? dst_q[i+1] : dst_q[i]);
      end else if (i == DEPTH - 1) begin : g_tail
         assign src_nxt[i] = shift_dn ? src_q[i-1] : (shift_up ? '0 : src_q[i]);
         assign dst_nxt[i] = shift_dn ? dst_q[i-1] : (shift_up ? '0 : dst_q[i]);
      end else begin : g_mid
         assign src_nxt[i] = shift_dn ? src_q[i-1] : (shift_up ? src_q[i+1] : src_q[i]);
         assign dst_nxt[i] = shift_dn ? dst_q[i-1] : (shift_up ? dst_q[i+1] : dst_q[i]);
      end
   end

   always_comb begin
      cnt_nxt = cnt_q;
      if (clear)                             cnt_nxt = '0;
      else if (shift_up)                     cnt_nxt = cnt_q - ONE_CNT;
      else if (shift_dn && cnt_q < FULL_CNT) cnt_nxt = cnt_q + ONE_CNT;
   end

   always_ff @(posedge clk) begin
      if (rst) cnt_q <= '0;
      else     cnt_q <= cnt_nxt;
   end

   if (RESET_DATA) begin : g_data_rst
      always_ff @(posedge clk) begin
         for (int j = 0; j < DEPTH; j++) begin
            if (rst) begin
               src_q[j] <= '0;
               dst_q[j] <= '0;
            end else begin
               src_q[j] <= src_nxt[j];
               dst_q[j] <= dst_nxt[j];
            end
         end
      end
   end else begin : g_data_free
      always_ff @(posedge clk) begin
         for (int j = 0; j < DEPTH; j++) begin
            src_q[j] <= src_nxt[j];
            dst_q[j] <= dst_nxt[j];
         end
      end
   end

   assign top_src = src_q[0];
   assign top_dst = dst_q[0];
   assign count   = cnt_q;

   logic [ADDR_W-1:0] second_src;
   assign second_src = src_q[1];

   // R4
   cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
      count <= FULL_CNT);
   // R4
   push_grow_chk: assert property (@(posedge clk) disable iff (rst)
      push && !pop_req && !clear && count < FULL_CNT |=> count == $past(count) + ONE_CNT);
   // R4
   full_sat_chk: assert property (@(posedge clk) disable iff (rst)
      push && !pop_req && !clear && count == FULL_CNT |=> count == FULL_CNT);
   // R10
   push_pop_keep_chk: assert property (@(posedge clk) disable iff (rst)
      push && pop_req && !clear && count != '0 |=> count == $past(count) && top_src == $past(push_src));
   // R7
   pop_shift_chk: assert property (@(posedge clk) disable iff (rst)
      pop_req && !push && !clear && count > ONE_CNT |=> top_src == $past(second_src) && count == $past(count) - ONE_CNT);
   // R8
   empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
      pop_req && !push && !clear && count == '0 |=> count == '0);
endmodule

// File: rtl/branch_trace_queue.sv
module branch_trace_queue
   import btq_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned DEPTH      = 8,
   parameter bit          RESET_DATA = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ev_valid,
   input  logic              ev_is_exc,
   input  logic [ADDR_W-1:0] ev_br_addr,
   input  logic [ADDR_W-1:0] ev_br_target,
   input  logic [ADDR_W-1:0] ev_exc_pc,
   input  logic [ADDR_W-1:0] ev_exc_handler,
   input  logic              ctrl_wr_en,
   input  logic              ctrl_wr_trace_en,
   input  logic              reg_rd_en,
   input  logic [1:0]        reg_addr,
   output logic [ADDR_W-1:0] reg_rdata
);
   localparam int unsigned CNT_W = $clog2(DEPTH + 1);

   initial begin
      assert (BTQ_CTRL_CNT_LSB + CNT_W <= ADDR_W)
         else $fatal(1, "branch_trace_queue: count field does not fit");
   end

   logic              trace_en, invalidate, capture, pop_req;
   logic [ADDR_W-1:0] sel_src, sel_dst, top_src, top_dst;
   logic [CNT_W-1:0]  count;
   btq_reg_e          rsel;

   assign rsel    = btq_reg_e'(reg_addr);
   assign capture = ev_valid && trace_en;
   assign pop_req = reg_rd_en && (rsel == BTQ_REG_DST);

   btq_ctrl i_ctrl (
      .clk        (clk),
      .rst        (rst),
      .wr_en      (ctrl_wr_en),
      .wr_val     (ctrl_wr_trace_en),
      .trace_en   (trace_en),
      .invalidate (invalidate)
   );

   btq_pair_select #(.ADDR_W(ADDR_W)) i_sel (
      .is_exc      (ev_is_exc),
      .br_addr     (ev_br_addr),
      .br_target   (ev_br_target),
      .exc_pc      (ev_exc_pc),
      .exc_handler (ev_exc_handler),
      .pair_src    (sel_src),
      .pair_dst    (sel_dst)
   );

   btq_lifo #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .RESET_DATA(RESET_DATA)) i_lifo (
      .clk      (clk),
      .rst      (rst),
      .clear    (invalidate),
      .push     (capture),
      .pop_req  (pop_req),
      .push_src (sel_src),
      .push_dst (sel_dst),
      .top_src  (top_src),
      .top_dst  (top_dst),
      .count    (count)
   );

   logic have_pair;
   assign have_pair = (count != '0);

   always_comb begin
      reg_rdata = '0;
      if (reg_rd_en) begin
         unique case (rsel)
            BTQ_REG_CTRL: begin
               reg_rdata[BTQ_CTRL_EN_BIT]               = trace_en;
               reg_rdata[BTQ_CTRL_CNT_LSB +: CNT_W]     = count;
            end
            BTQ_REG_SRC:  reg_rdata = have_pair ? top_src : '0;
            BTQ_REG_DST:  reg_rdata = have_pair ? top_dst : '0;
            default:      reg_rdata = '0;
         endcase
      end
   end

   // R1
   no_capture_off_chk: assert property (@(posedge clk) disable iff (rst)
      ev_valid && !trace_en && !pop_req && !ctrl_wr_en |=> count == $past(count));
   // R2
   branch_pair_chk: assert property (@(posedge clk) disable iff (rst)
      capture && !ev_is_exc |=> top_src == $past(ev_br_addr) && top_dst == $past(ev_br_target));
   // R3
   exc_pair_chk: assert property (@(posedge clk) disable iff (rst)
      capture && ev_is_exc |=> top_src == $past(ev_exc_pc) && top_dst == $past(ev_exc_handler));
   // R6
   src_read_hold_chk: assert property (@(posedge clk) disable iff (rst)
      reg_rd_en && rsel == BTQ_REG_SRC && !ev_valid && !ctrl_wr_en
      |=> count == $past(count) && top_src == $past(top_src));
   // R9
   reenable_clear_chk: assert property (@(posedge clk) disable iff (rst)
      ctrl_wr_en && ctrl_wr_trace_en && !trace_en |=> count == '0);
   // R8
   empty_zero_chk: assert property (@(posedge clk) disable iff (rst)
      reg_rd_en && count == '0 && rsel != BTQ_REG_CTRL |-> reg_rdata == '0);
endmodule

// File: tb/test_branch_trace_queue.sv
module test_branch_trace_queue;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ev_valid = 0, ev_is_exc = 0;
   logic [31:0] ev_br_addr = 0, ev_br_target = 0, ev_exc_pc = 0, ev_exc_handler = 0;
   logic        ctrl_wr_en = 0, ctrl_wr_trace_en = 0, reg_rd_en = 0;
   logic [1:0]  reg_addr = 0;
   logic [31:0] reg_rdata;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   branch_trace_queue i_branch_trace_queue (
      .clk(clk), .rst(rst),
      .ev_valid(ev_valid), .ev_is_exc(ev_is_exc),
      .ev_br_addr(ev_br_addr), .ev_br_target(ev_br_target),
      .ev_exc_pc(ev_exc_pc), .ev_exc_handler(ev_exc_handler),
      .ctrl_wr_en(ctrl_wr_en), .ctrl_wr_trace_en(ctrl_wr_trace_en),
      .reg_rd_en(reg_rd_en), .reg_addr(reg_addr), .reg_rdata(reg_rdata)
   );

   // Bench reference: index 0 is the newest pair
   logic [31:0] ms [8];
   logic [31:0] md [8];
   int          mcnt = 0;
   bit          men  = 0;

   function automatic logic [31:0] f_br(int k);  return 32'h0800_0000 + 32'(k) * 4; endfunction
   function automatic logic [31:0] f_tg(int k);  return 32'h0C00_0000 ^ (32'(k) << 8); endfunction
   function automatic logic [31:0] f_epc(int k); return 32'hA000_0000 + 32'(k) * 2; endfunction
   function automatic logic [31:0] f_hnd(int k); return 32'h8000_0100 + 32'(k % 4) * 32'h100; endfunction

   function automatic logic [31:0] model_read(logic [1:0] a);
      case (a)
         2'd0: return (32'(mcnt) << 4) | 32'(men);
         2'd1: return (mcnt > 0) ? ms[0] : 32'h0;
         2'd2: return (mcnt > 0) ? md[0] : 32'h0;
         default: return 32'h0;
      endcase
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input bit ev, input bit exc, input int k, input bit rd,
                       input logic [1:0] a, input bit wr, input bit wen,
                       output logic [31:0] got);
      @(negedge clk);
      ev_valid = ev; ev_is_exc = exc;
      ev_br_addr = f_br(k); ev_br_target = f_tg(k);
      ev_exc_pc = f_epc(k); ev_exc_handler = f_hnd(k);
      reg_rd_en = rd; reg_addr = a;
      ctrl_wr_en = wr; ctrl_wr_trace_en = wen;
      #1 got = reg_rdata;
      @(posedge clk);
      // reference update: pop first, then push, then the control write
      if (rd && a == 2'd2 && mcnt > 0) begin
         for (int j = 0; j < 7; j++) begin ms[j] = ms[j+1]; md[j] = md[j+1]; end
         mcnt--;
      end
      if (ev && men) begin
         for (int j = 7; j > 0; j--) begin ms[j] = ms[j-1]; md[j] = md[j-1]; end
         ms[0] = exc ? f_epc(k) : f_br(k);
         md[0] = exc ? f_hnd(k) : f_tg(k);
         if (mcnt < 8) mcnt++;
      end
      if (wr) begin
         if (wen && !men) mcnt = 0;
         men = wen;
      end
   endtask

   task automatic ev_push(bit exc, int k);
      logic [31:0] g;
      step(1, exc, k, 0, 2'd0, 0, 0, g);
   endtask

   task automatic set_en(bit v);
      logic [31:0] g;
      step(0, 0, 0, 0, 2'd0, 1, v, g);
   endtask

   task automatic rd_chk(logic [1:0] a, string tag);
      logic [31:0] g, e;
      e = model_read(a);
      step(0, 0, 0, 1, a, 0, 0, g);
      chk(tag, g, e);
   endtask

   task automatic rd_val(logic [1:0] a, output logic [31:0] g);
      step(0, 0, 0, 1, a, 0, 0, g);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] g, e, first;
      repeat (3) @(posedge clk);
      @(negedge clk) rst = 0;

      // R11 reset state
      rd_val(2'd0, g); chk("R11 reset ctrl", g, 32'h0);
      rd_val(2'd1, g); chk("R8 reset src", g, 32'h0);
      rd_val(2'd3, g); chk("R5 reserved", g, 32'h0);

      // R1 capture ignored while off
      ev_push(0, 99);
      rd_val(2'd0, g); chk("R1 off count", g, 32'h0);

      // Sweep capture count 0..11 with mixed event kinds
      for (int n = 0; n <= 11; n++) begin
         set_en(0);
         set_en(1);
         rd_val(2'd0, g); chk("R9 cleared", g, 32'h1);
         for (int i = 0; i < n; i++) ev_push(i % 3 == 2, n * 16 + i);
         rd_val(2'd0, g);
         chk("R4 count", g, 32'((n < 8 ? n : 8) << 4) | 32'h1);
         for (int j = 0; j < (n < 8 ? n : 8); j++) begin
            // newest first: entry j is event n-1-j
            int k;
            bit x;
            k = n * 16 + (n - 1 - j);
            x = ((n - 1 - j) % 3 == 2);
            rd_val(2'd1, g); chk(x ? "R3 src" : "R2 src", g, x ? f_epc(k) : f_br(k));
            rd_val(2'd1, g); chk("R6 src repeat", g, x ? f_epc(k) : f_br(k));
            rd_val(2'd2, g); chk(x ? "R3 dst" : "R2 dst", g, x ? f_hnd(k) : f_tg(k));
            rd_val(2'd0, g);
            chk("R7 count drop", g, 32'(((n < 8 ? n : 8) - 1 - j) << 4) | 32'h1);
         end
         rd_chk(2'd1, "R8 empty src");
         rd_val(2'd2, g); chk("R8 empty dst", g, 32'h0);
         rd_val(2'd0, g); chk("R8 empty count", g, 32'h1);
      end

      // R10 capture together with destination read
      set_en(0); set_en(1);
      ev_push(0, 500); ev_push(1, 501); ev_push(0, 502);
      e = f_tg(502);
      step(1, 0, 503, 1, 2'd2, 0, 0, g);
      chk("R10 popped old top", g, e);
      rd_val(2'd0, g); chk("R10 count kept", g, 32'h31);
      rd_val(2'd1, g); chk("R10 new top", g, f_br(503));
      rd_val(2'd2, g);
      rd_val(2'd1, g); chk("R10 older kept", g, f_epc(501));
      rd_chk(2'd2, "R10 older dst");

      // R9 disable keeps entries, re-enable discards them
      set_en(0); set_en(1);
      ev_push(1, 600); ev_push(0, 601);
      set_en(0);
      rd_val(2'd0, g); chk("R9 off keeps", g, 32'h20);
      rd_val(2'd1, g); chk("R9 readable off", g, f_br(601));
      ev_push(0, 602);
      rd_val(2'd1, g); chk("R1 no capture", g, f_br(601));
      set_en(1);
      rd_val(2'd0, g); chk("R9 reenable count", g, 32'h1);
      rd_val(2'd1, g); chk("R9 invalid src", g, 32'h0);

      // R4 overflow: keep the newest eight of ten, oldest dropped
      for (int i = 0; i < 10; i++) ev_push(i[0], 700 + i);
      first = 32'h0;
      for (int j = 0; j < 8; j++) begin
         rd_val(2'd1, g);
         first = g;
         rd_val(2'd2, g);
      end
      chk("R4 oldest kept", first, f_br(702));
      rd_val(2'd0, g); chk("R4 drained", g, 32'h1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule